// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This unit resolves control-transfer instructions for a virtual machine whose registers are 64 bits wide. For each request it takes a 4-bit jump code, a class bit that selects a full-width compare or a 32-bit compare, a register-or-immediate source select, the source register field, both operand values, the program counter, a 16-bit signed offset and a 32-bit signed immediate. It returns one result per request: whether the branch is taken, the next program counter, and flags for a function call, a return or an illegal encoding. The program counter counts 64-bit instruction slots. Every displacement is added to the slot that follows the jump.

Requests arrive on a valid/ready interface and results leave on another. The unit has one output register. A request is accepted in a cycle where `in_valid` and `in_ready` are both high. Its result appears on the next cycle. `in_ready` is high whenever the output register is empty or is being drained in that same cycle. When `out_valid` is high and `out_ready` is low, the result is held unchanged and no new request is accepted. Results come out in the order the requests were accepted. Calls and returns are only flagged: helper execution, stack frames and operand fetch are handled elsewhere.

Top module: `brn_resolve_unit`

## Requirements
- R1: After reset `out_valid` is 0.
- R2: `in_ready` is high exactly when `out_valid` is 0 or `out_ready` is 1. While `out_valid` is 1 and `out_ready` is 0, every result output holds its value.
- R3: Code 1 (equal), code 5 (not equal) and code 4 (taken when the bitwise AND of the two operands is nonzero) resolve correctly.
- R4: The unsigned codes resolve correctly: 2 (greater than), 3 (greater or equal), 10 (less than) and 11 (less or equal).
- R5: The signed two's-complement codes resolve correctly: 6 (greater than), 7 (greater or equal), 12 (less than) and 13 (less or equal).
- R6: With `in_narrow`=1, only bits 31:0 of each operand are compared, and signed codes treat bit 31 as the sign bit.
- R7: With `in_use_reg`=0, the comparand is the immediate sign-extended to 64 bits, in place of `in_src`.
- R8: A taken conditional branch gives `in_pc`+1+sign-extended offset. A result that is not taken gives `in_pc`+1. Both wrap modulo 2^64.
- R9: Code 0 is always taken. Its displacement is the offset when `in_narrow`=0 and the immediate when `in_narrow`=1.
- R10: Code 8 with `in_narrow`=0 and `in_use_reg`=0 is a call, and `out_call_kind` takes the value of the source field. Kind 1 (local call) is taken with target `in_pc`+1+immediate. Kinds 0 (helper by static id) and 2 (helper by type id) are not taken.
- R11: Code 9 with `in_narrow`=0 sets `out_exit`, is not taken and gives `in_pc`+1.
- R12: The following are illegal: code 8 or 9 with `in_narrow`=1, code 8 with `in_use_reg`=1, code 8 with a source field above 2, and codes 14 and 15. An illegal request sets `out_illegal` with no call, no exit, not taken and `in_pc`+1.
- R13: Each accepted request produces exactly one result, on the following cycle when `out_ready` allows, in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_code | input | 4 | Jump code |
| in_narrow | input | 1 | 1 = 32-bit compare class, 0 = 64-bit class |
| in_use_reg | input | 1 | 1 = source is the register value, 0 = the immediate |
| in_src_field | input | 4 | Source register field (selects the call kind) |
| in_dst | input | 64 | Destination operand value |
| in_src | input | 64 | Source operand value |
| in_pc | input | 64 | Program counter of the jump, in slots |
| in_offset | input | 16 | Signed slot offset |
| in_imm | input | 32 | Signed immediate |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer accepts the result |
| out_taken | output | 1 | Control transfers to a displaced target |
| out_next_pc | output | 64 | Next program counter |
| out_call | output | 1 | Call request |
| out_call_kind | output | 2 | 0 static helper, 1 local, 2 typed helper |
| out_exit | output | 1 | Return request |
| out_illegal | output | 1 | Illegal encoding |

## Verification
The assertions check the properties that can be judged one cycle at a time: results held under back-pressure, one result after each accepted request, PC+1 on every result that is not taken, the call, exit and illegal flags never set together, and illegal, exit and helper-call results never taken. Whether a comparison is decided correctly shows up only in the bench's scenarios. These compare every output against a behavioural model, with operands chosen near sign and width boundaries, immediate comparands, wrapping targets and random stalls.

// File: rtl/brn_pkg.sv
package brn_pkg;

  localparam int CODE_W = 4;
  localparam int KIND_W = 2;

  typedef enum logic [CODE_W-1:0] {
    JC_ALWAYS = 4'h0,
    JC_EQ     = 4'h1,
    JC_UGT    = 4'h2,
    JC_UGE    = 4'h3,
    JC_TEST   = 4'h4,
    JC_NE     = 4'h5,
    JC_SGT    = 4'h6,
    JC_SGE    = 4'h7,
    JC_CALL   = 4'h8,
    JC_RET    = 4'h9,
    JC_ULT    = 4'ha,
    JC_ULE    = 4'hb,
    JC_SLT    = 4'hc,
    JC_SLE    = 4'hd,
    JC_RSV_E  = 4'he,
    JC_RSV_F  = 4'hf
  } jcode_e;

  typedef enum logic [KIND_W-1:0] {
    CK_HELPER_ID  = 2'd0,
    CK_LOCAL      = 2'd1,
    CK_HELPER_TYP = 2'd2,
    CK_NONE       = 2'd3
  } call_kind_e;

  typedef enum logic [1:0] {
    DISP_NONE = 2'd0,
    DISP_OFF  = 2'd1,
    DISP_IMM  = 2'd2
  } disp_sel_e;

  typedef struct packed {
    logic       taken;
    logic       call;
    call_kind_e kind;
    logic       ret;
    logic       illegal;
  } res_flags_t;

endpackage

// File: rtl/brn_cond_eval.sv
module brn_cond_eval
  import brn_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32
) (
  input  jcode_e              code,
  input  logic                narrow,
  input  logic [DATA_W-1:0]   lhs,
  input  logic [DATA_W-1:0]   rhs,
  output logic                hold
);

  localparam int NVAR = 2;

  logic [NVAR-1:0] eq_v;
  logic [NVAR-1:0] ult_v;
  logic [NVAR-1:0] slt_v;
  logic [NVAR-1:0] tst_v;

  // one comparator set per compare width; variant 0 is full width
  generate
    for (genvar g = 0; g < NVAR; g++) begin : g_width
      localparam int W = (g == 0) ? DATA_W : NARROW_W;
      logic [W-1:0] a;
      logic [W-1:0] b;
      assign a        = lhs[W-1:0];
      assign b        = rhs[W-1:0];
      assign eq_v[g]  = (a == b);
      assign ult_v[g] = (a < b);
      assign slt_v[g] = ($signed(a) < $signed(b));
      assign tst_v[g] = |(a & b);
    end
  endgenerate

  logic eq, ult, slt, tst;
  always_comb begin
    eq  = narrow ? eq_v[1]  : eq_v[0];
    ult = narrow ? ult_v[1] : ult_v[0];
    slt = narrow ? slt_v[1] : slt_v[0];
    tst = narrow ? tst_v[1] : tst_v[0];
  end

  always_comb begin
    case (code)
      JC_EQ:   hold = eq;
      JC_NE:   hold = !eq;
      JC_TEST: hold = tst;
      JC_UGT:  hold = !ult && !eq;
      JC_UGE:  hold = !ult;
      JC_ULT:  hold = ult;
      JC_ULE:  hold = ult || eq;
      JC_SGT:  hold = !slt && !eq;
      JC_SGE:  hold = !slt;
      JC_SLT:  hold = slt;
      JC_SLE:  hold = slt || eq;
      default: hold = 1'b0;
    endcase
  end

endmodule

// File: rtl/brn_decode.sv
module brn_decode
  import brn_pkg::*;
#(
  parameter int SRCF_W = 4
) (
  input  jcode_e             code,
  input  logic               narrow,
  input  logic               use_reg,
  input  logic [SRCF_W-1:0]  src_field,
  input  logic               cond_hold,
  output res_flags_t         flags,
  output disp_sel_e          disp_sel
);

  localparam logic [SRCF_W-1:0] SF_HELPER = SRCF_W'(0);
  localparam logic [SRCF_W-1:0] SF_LOCAL  = SRCF_W'(1);
  localparam logic [SRCF_W-1:0] SF_TYPED  = SRCF_W'(2);

  always_comb begin
    flags    = '{taken: 1'b0, call: 1'b0, kind: CK_NONE, ret: 1'b0, illegal: 1'b0};
    disp_sel = DISP_NONE;
    case (code)
      JC_ALWAYS: begin
        flags.taken = 1'b1;
        disp_sel    = narrow ? DISP_IMM : DISP_OFF;
      end
      JC_CALL: begin
        if (narrow || use_reg) begin
          flags.illegal = 1'b1;
        end else if (src_field == SF_LOCAL) begin
          flags.call  = 1'b1;
          flags.kind  = CK_LOCAL;
          flags.taken = 1'b1;
          disp_sel    = DISP_IMM;
        end else if (src_field == SF_HELPER) begin
          flags.call = 1'b1;
          flags.kind = CK_HELPER_ID;
        end else if (src_field == SF_TYPED) begin
          flags.call = 1'b1;
          flags.kind = CK_HELPER_TYP;
        end else begin
          flags.illegal = 1'b1;
        end
      end
      JC_RET: begin
        if (narrow) flags.illegal = 1'b1;
        else        flags.ret     = 1'b1;
      end
      JC_RSV_E, JC_RSV_F: begin
        flags.illegal = 1'b1;
      end
      default: begin
        flags.taken = cond_hold;
        disp_sel    = cond_hold ? DISP_OFF : DISP_NONE;
      end
    endcase
  end

endmodule

// File: rtl/brn_target.sv
module brn_target
  import brn_pkg::*;
#(
  parameter int PC_W  = 64,
  parameter int OFF_W = 16,
  parameter int IMM_W = 32
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [OFF_W-1:0] offset,
  input  logic [IMM_W-1:0] imm,
  input  disp_sel_e        sel,
  output logic [PC_W-1:0]  next_pc
);

  localparam int OFF_EXT = PC_W - OFF_W;
  localparam int IMM_EXT = PC_W - IMM_W;

  logic [PC_W-1:0] disp;
  logic [PC_W-1:0] seq_pc;

  always_comb begin
    case (sel)
      DISP_OFF: disp = {{OFF_EXT{offset[OFF_W-1]}}, offset};
      DISP_IMM: disp = {{IMM_EXT{imm[IMM_W-1]}}, imm};
      default:  disp = '0;
    endcase
  end

  assign seq_pc  = pc + PC_W'(1);
  assign next_pc = seq_pc + disp;

endmodule

// File: rtl/brn_resolve_unit.sv
module brn_resolve_unit
  import brn_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  parameter int PC_W     = 64,
  parameter int OFF_W    = 16,
  parameter int IMM_W    = 32,
  parameter int SRCF_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [CODE_W-1:0]   in_code,
  input  logic                in_narrow,
  input  logic                in_use_reg,
  input  logic [SRCF_W-1:0]   in_src_field,
  input  logic [DATA_W-1:0]   in_dst,
  input  logic [DATA_W-1:0]   in_src,
  input  logic [PC_W-1:0]     in_pc,
  input  logic [OFF_W-1:0]    in_offset,
  input  logic [IMM_W-1:0]    in_imm,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                out_taken,
  output logic [PC_W-1:0]     out_next_pc,
  output logic                out_call,
  output logic [KIND_W-1:0]   out_call_kind,
  output logic                out_exit,
  output logic                out_illegal
);

  localparam int IMM_PAD = DATA_W - IMM_W;

  jcode_e           code;
  logic [DATA_W-1:0] rhs;
  logic             cond_hold;
  res_flags_t       flags;
  disp_sel_e        disp_sel;
  logic [PC_W-1:0]  next_pc;

  assign code = jcode_e'(in_code);
  assign rhs  = in_use_reg ? in_src : {{IMM_PAD{in_imm[IMM_W-1]}}, in_imm};

  brn_cond_eval #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) i_cond (
    .code   (code),
    .narrow (in_narrow),
    .lhs    (in_dst),
    .rhs    (rhs),
    .hold   (cond_hold)
  );

  brn_decode #(.SRCF_W(SRCF_W)) i_dec (
    .code      (code),
    .narrow    (in_narrow),
    .use_reg   (in_use_reg),
    .src_field (in_src_field),
    .cond_hold (cond_hold),
    .flags     (flags),
    .disp_sel  (disp_sel)
  );

  brn_target #(.PC_W(PC_W), .OFF_W(OFF_W), .IMM_W(IMM_W)) i_tgt (
    .pc      (in_pc),
    .offset  (in_offset),
    .imm     (in_imm),
    .sel     (disp_sel),
    .next_pc (next_pc)
  );

  // single output register; refills in the cycle it drains
  assign in_ready = !out_valid || out_ready;

  res_flags_t      res_q;
  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_q     <= '{taken: 1'b0, call: 1'b0, kind: CK_NONE, ret: 1'b0, illegal: 1'b0};
      pc_q      <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_q <= flags;
        pc_q  <= next_pc;
      end
    end
  end

  assign out_taken     = res_q.taken;
  assign out_next_pc   = pc_q;
  assign out_call      = res_q.call;
  assign out_call_kind = res_q.call ? res_q.kind : KIND_W'(0);
  assign out_exit      = res_q.ret;
  assign out_illegal   = res_q.illegal;

endmodule

// File: rtl/brn_resolve_chk.sv
module brn_resolve_chk #(
  parameter int PC_W = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [PC_W-1:0] in_pc,
  input logic            out_valid,
  input logic            out_ready,
  input logic            out_taken,
  input logic [PC_W-1:0] out_next_pc,
  input logic            out_call,
  input logic [1:0]      out_call_kind,
  input logic            out_exit,
  input logic            out_illegal
);

  assert_hold_under_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_next_pc) && $stable(out_taken)
      && $stable(out_call) && $stable(out_call_kind) && $stable(out_exit) && $stable(out_illegal)));

  assert_no_accept_when_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_result_follows_accept_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_fallthrough_pc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_taken || out_next_pc == $past(in_pc) + PC_W'(1)));

  assert_illegal_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (!out_taken && !out_call && !out_exit));

  assert_exit_not_taken_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_exit) |-> (!out_taken && !out_call));

  assert_helper_not_taken_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_call && out_call_kind != 2'd1) |-> !out_taken);

  assert_flags_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_call, out_exit, out_illegal}));

endmodule

bind brn_resolve_unit brn_resolve_chk #(.PC_W(PC_W)) i_chk (.*);

// File: tb/test_brn_resolve_unit.sv
module test_brn_resolve_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_code = '0;
  logic        in_narrow = 1'b0;
  logic        in_use_reg = 1'b1;
  logic [3:0]  in_src_field = '0;
  logic [63:0] in_dst = '0;
  logic [63:0] in_src = '0;
  logic [63:0] in_pc = '0;
  logic [15:0] in_offset = '0;
  logic [31:0] in_imm = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_taken;
  logic [63:0] out_next_pc;
  logic        out_call;
  logic [1:0]  out_call_kind;
  logic        out_exit;
  logic        out_illegal;

  int checks = 0;
  int errors = 0;
  bit stall_en = 1'b0;
  bit done = 1'b0;
  string cur_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  brn_resolve_unit i_brn_resolve_unit (.*);

  typedef struct {
    bit              taken;
    longint unsigned npc;
    bit              call;
    bit [1:0]        kind;
    bit              ret;
    bit              ill;
  } exp_t;

  function automatic exp_t ref_fn(bit [3:0] c, bit n, bit ur, bit [3:0] sf,
                                  bit [63:0] d, bit [63:0] s, bit [63:0] pc,
                                  bit [15:0] off, bit [31:0] imm);
    exp_t r;
    longint unsigned immx = {{32{imm[31]}}, imm};
    longint unsigned offx = {{48{off[15]}}, off};
    longint unsigned opb  = ur ? s : immx;
    longint unsigned ua, ub;
    longint sa, sb;
    bit hit = 0;
    if (n) begin
      ua = d[31:0]; ub = opb[31:0];
      sa = longint'($signed(d[31:0])); sb = longint'($signed(opb[31:0]));
    end else begin
      ua = d; ub = opb; sa = $signed(d); sb = $signed(opb);
    end
    r = '{taken: 0, npc: pc + 1, call: 0, kind: 0, ret: 0, ill: 0};
    case (c)
      4'h0: begin r.taken = 1; r.npc = pc + 1 + (n ? immx : offx); end
      4'h1: hit = (ua == ub);
      4'h2: hit = (ua > ub);
      4'h3: hit = (ua >= ub);
      4'h4: hit = ((ua & ub) != 0);
      4'h5: hit = (ua != ub);
      4'h6: hit = (sa > sb);
      4'h7: hit = (sa >= sb);
      4'ha: hit = (ua < ub);
      4'hb: hit = (ua <= ub);
      4'hc: hit = (sa < sb);
      4'hd: hit = (sa <= sb);
      4'h8: begin
        if (n || ur || sf > 2) r.ill = 1;
        else begin
          r.call = 1; r.kind = sf[1:0];
          if (sf == 1) begin r.taken = 1; r.npc = pc + 1 + immx; end
        end
      end
      4'h9: if (n) r.ill = 1; else r.ret = 1;
      default: r.ill = 1;
    endcase
    if (hit) begin r.taken = 1; r.npc = pc + 1 + offx; end
    return r;
  endfunction

  // behavioural model: one pending result
  bit    mv = 0;
  exp_t  me;
  string mtag = "R1";

  always @(posedge clk) begin
    if (!rst_n) mv <= 0;
    else if (!mv || out_ready) begin
      mv <= in_valid;
      if (in_valid) begin
        me   <= ref_fn(in_code, in_narrow, in_use_reg, in_src_field, in_dst, in_src,
                       in_pc, in_offset, in_imm);
        mtag <= cur_tag;
      end
    end
  end

  // output ready changes just after each rising edge
  always @(posedge clk) begin
    #1;
    out_ready = stall_en ? ($urandom_range(3) != 0) : 1'b1;
  end

  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (!done) begin
        checks++;
        if (out_valid !== mv) begin
          errors++;
          $display("FAIL %s out_valid actual=%0b expected=%0b", mtag, out_valid, mv);
        end
        checks++;
        if (in_ready !== (!mv || out_ready)) begin
          errors++;
          $display("FAIL R2 in_ready actual=%0b expected=%0b", in_ready, (!mv || out_ready));
        end
        if (mv) begin
          checks++;
          if (out_taken !== me.taken || out_next_pc !== me.npc || out_call !== me.call ||
              out_call_kind !== me.kind || out_exit !== me.ret || out_illegal !== me.ill) begin
            errors++;
            $display("FAIL %s actual t=%0b pc=%h c=%0b k=%0d x=%0b i=%0b expected t=%0b pc=%h c=%0b k=%0d x=%0b i=%0b",
                     mtag, out_taken, out_next_pc, out_call, out_call_kind, out_exit, out_illegal,
                     me.taken, me.npc, me.call, me.kind, me.ret, me.ill);
          end
        end
      end
    end
  end

  task automatic send(input string tag, input bit [3:0] c, input bit n, input bit ur,
                      input bit [3:0] sf, input bit [63:0] d, input bit [63:0] s,
                      input bit [63:0] pc, input bit [15:0] off, input bit [31:0] imm);
    cur_tag = tag;
    in_code = c; in_narrow = n; in_use_reg = ur; in_src_field = sf;
    in_dst = d; in_src = s; in_pc = pc; in_offset = off; in_imm = imm;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic bit [63:0] pick_val();
    case ($urandom_range(7))
      0: return 64'h0;
      1: return 64'hFFFF_FFFF_FFFF_FFFF;
      2: return 64'h8000_0000_0000_0000;
      3: return 64'h0000_0000_8000_0000;
      4: return 64'h0000_0000_FFFF_FFFF;
      5: return {60'h0, 4'($urandom_range(15))};
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset out_valid actual=%0b expected=0", out_valid);
    end
    // R3 equality and bit test
    send("R3", 4'h1, 0, 1, 0, 64'd5, 64'd5, 64'd100, -16'sd3, 0);
    send("R3", 4'h5, 0, 1, 0, 64'd5, 64'd5, 64'd100, 16'd7, 0);
    send("R3", 4'h4, 0, 1, 0, 64'h10, 64'h30, 64'd200, 16'd4, 0);
    send("R3", 4'h4, 0, 1, 0, 64'h0f, 64'hf0, 64'd200, 16'd4, 0);
    // R4 unsigned
    send("R4", 4'h2, 0, 1, 0, '1, 64'd1, 64'd10, 16'd2, 0);
    send("R4", 4'ha, 0, 1, 0, '1, 64'd1, 64'd10, 16'd2, 0);
    send("R4", 4'h3, 0, 1, 0, 64'd9, 64'd9, 64'd10, 16'd2, 0);
    send("R4", 4'hb, 0, 1, 0, 64'd9, 64'd9, 64'd10, 16'd2, 0);
    // R5 signed
    send("R5", 4'h6, 0, 1, 0, '1, 64'd1, 64'd10, 16'd5, 0);
    send("R5", 4'hc, 0, 1, 0, '1, 64'd1, 64'd10, 16'd5, 0);
    send("R5", 4'h7, 0, 1, 0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'd10, 16'd5, 0);
    send("R5", 4'hd, 0, 1, 0, 64'd3, 64'd2, 64'd10, 16'd5, 0);
    // R6 narrow class
    send("R6", 4'h1, 1, 1, 0, 64'h1_0000_0005, 64'd5, 64'd50, 16'd8, 0);
    send("R6", 4'hc, 1, 1, 0, 64'h8000_0000, 64'd0, 64'd50, 16'd8, 0);
    send("R6", 4'hc, 0, 1, 0, 64'h8000_0000, 64'd0, 64'd50, 16'd8, 0);
    // R7 immediate comparand
    send("R7", 4'h1, 0, 0, 0, '1, 64'd0, 64'd60, 16'd1, 32'hFFFF_FFFF);
    send("R7", 4'h1, 1, 0, 0, 64'hFFFF_FFFF, 64'd0, 64'd60, 16'd1, 32'hFFFF_FFFF);
    // R8 wrapping targets
    send("R8", 4'h1, 0, 1, 0, 64'd0, 64'd0, 64'd0, 16'hFFFE, 0);
    send("R8", 4'h5, 0, 1, 0, 64'd0, 64'd0, '1, 16'd9, 0);
    // R9 unconditional
    send("R9", 4'h0, 0, 1, 0, 0, 0, 64'd1000, 16'd20, 32'd500);
    send("R9", 4'h0, 1, 1, 0, 0, 0, 64'd1000, 16'd20, -32'sd500);
    // R10 calls
    send("R10", 4'h8, 0, 0, 4'd0, 0, 0, 64'd300, 0, 32'd77);
    send("R10", 4'h8, 0, 0, 4'd1, 0, 0, 64'd300, 0, -32'sd30);
    send("R10", 4'h8, 0, 0, 4'd2, 0, 0, 64'd300, 0, 32'd77);
    // R11 return
    send("R11", 4'h9, 0, 1, 0, 0, 0, 64'd400, 16'd3, 0);
    // R12 illegal forms
    send("R12", 4'h8, 1, 0, 4'd1, 0, 0, 64'd500, 0, 32'd4);
    send("R12", 4'h8, 0, 1, 4'd1, 0, 0, 64'd500, 0, 32'd4);
    send("R12", 4'h8, 0, 0, 4'd3, 0, 0, 64'd500, 0, 32'd4);
    send("R12", 4'h9, 1, 1, 0, 0, 0, 64'd500, 0, 0);
    send("R12", 4'he, 0, 1, 0, 0, 0, 64'd500, 16'd2, 0);
    send("R12", 4'hf, 1, 1, 0, 0, 0, 64'd500, 16'd2, 0);
    // R13 back-to-back traffic under random back-pressure
    stall_en = 1'b1;
    for (int k = 0; k < 3000; k++) begin
      send("R13", 4'($urandom_range(15)), 1'($urandom_range(1)), 1'($urandom_range(1)),
           4'($urandom_range(4)), pick_val(), pick_val(), pick_val(),
           16'($urandom), $urandom);
    end
    in_valid = 1'b0;
    stall_en = 1'b0;
    repeat (6) @(negedge clk);
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule